// File: doc/BRIEF.md
# Windowed Threshold Pattern Trigger

This block follows a stream of samples. Each sample arrives as a pair of comparator bits, one against an upper reference and one against a lower reference. The block turns each pair into a class: High, Low, Middle, or an invalid code for a combination that cannot occur. Each class is stored in a circular history. The stored sample and the seven samples before it form an eight-sample window. Each time a sample is accepted, that window is compared against a bank of programmable patterns. In every window position a pattern asks for High, Low or Middle, or accepts any class.

Software loads the patterns and their enable bits through a small write port, then arms the block. While the block is armed, accepted samples overwrite the history. When an enabled pattern matches, the block raises its trigger and stops writing. It then reports the history entry of the newest sample in the matching window and the number of the winning pattern. The history stays frozen for readout through a read port until the next arm pulse, which clears the trigger and continues writing at the following entry.

Top module: `wtrig_top`

## Requirements
- R1: The class is taken from (cmp_hi, cmp_lo). (1,1) is High, code 2'b10. (0,1) is Middle, code 2'b11. (0,0) is Low, code 2'b01. (1,0) is invalid, code 2'b00. The read port shows these codes.
- R2: A pattern has 2 bits per position. 00 accepts any class, 01 asks for Low, 10 for High and 11 for Middle. Bits [2j+1:2j] apply to the sample j places older than the newest, so bits [1:0] apply to the newest sample.
- R3: A sample with the invalid class satisfies only a position coded 00.
- R4: A write with cfg_addr below 72 stores cfg_data[15:0] as the pattern and cfg_data[16] as its enable. Writes to addresses 72 to 127 change nothing. A disabled pattern never fires. After reset every pattern is zero and disabled.
- R5: Accepted samples are written at a pointer that starts at entry 0 after reset, steps by one and wraps from 127 to 0. A window may span entries 127 and 0.
- R6: After reset the block is disarmed. A sample is accepted only while the block is armed and not triggered.
- R7: trig rises exactly two clock edges after the edge that accepts the sample completing a matching window.
- R8: While trig is high, trig_ptr holds the entry of the newest sample of the matching window and trig_id holds the lowest-numbered enabled pattern that matched. Both stay constant until the next arm pulse.
- R9: After a match, only the sample accepted on the cycle right after the matching sample can still be written. No further entry changes until the next arm pulse.
- R10: An arm pulse sets armed, clears trig and discards evaluations still in flight. A sample presented in the same cycle as the arm pulse is dropped. Writing then continues at the entry after the last one written.
- R11: A pattern of High and Low alternating, with High in the newest position, fires on an alternating High/Low stream once a High sample completes eight samples.
- R12: rd_class shows, in the same cycle, the class stored at history entry rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A sample is present this cycle |
| cmp_hi | input | 1 | Sample is above the upper reference |
| cmp_lo | input | 1 | Sample is above the lower reference |
| cfg_we | input | 1 | Pattern write strobe |
| cfg_addr | input | 7 | Pattern number to write |
| cfg_data | input | 17 | Enable bit 16, pattern bits 15:0 |
| arm | input | 1 | Arm or re-arm pulse |
| rd_addr | input | 7 | History entry to read |
| rd_class | output | 2 | Class stored at rd_addr |
| armed | output | 1 | Block is armed |
| trig | output | 1 | Trigger flag |
| trig_ptr | output | 7 | Entry of the newest sample of the matching window |
| trig_id | output | 7 | Lowest matching pattern number |

## Verification
Two pairs of events can fall in the same cycle. In the first, an arm pulse arrives together with a valid sample; the sample must be dropped and the next sample must land in the entry after the last one written. In the second, a sample arrives on the cycle right after a matching sample, while the match is still in the pipeline; that sample must be written and must not move the reported entry or pattern. Both are provoked with directed sequences and then many times at random, and a behavioural model in the bench predicts every output and every history entry and judges them.

// File: rtl/wtrig_pkg.sv
package wtrig_pkg;

    // Sample class codes; equal to the pattern codes that request them.
    typedef enum logic [1:0] {
        CLS_BAD  = 2'b00,
        CLS_LOW  = 2'b01,
        CLS_HIGH = 2'b10,
        CLS_MID  = 2'b11
    } cls_e;

    // Pattern position code that accepts anything.
    localparam logic [1:0] CODE_ANY = 2'b00;

    function automatic cls_e classify(input logic above_hi, input logic above_lo);
        cls_e c;
        case ({above_hi, above_lo})
            2'b11:   c = CLS_HIGH;
            2'b01:   c = CLS_MID;
            2'b00:   c = CLS_LOW;
            default: c = CLS_BAD;
        endcase
        return c;
    endfunction

    function automatic logic pos_match(input cls_e c, input logic [1:0] code);
        return (code == CODE_ANY) || ((c != CLS_BAD) && (c == cls_e'(code)));
    endfunction

endpackage

// File: rtl/wtrig_history.sv
module wtrig_history
    import wtrig_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIN   = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  cls_e            cls_in,
    input  logic [PW-1:0]   rd_addr,
    output cls_e            rd_cls,
    output logic [PW-1:0]   wr_ptr,
    output logic [PW-1:0]   newest_ptr,
    output logic [2*WIN-1:0] window
);

    cls_e          mem [DEPTH];
    logic [PW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CLS_BAD;
            ptr_q      <= '0;
            newest_ptr <= '0;
            window     <= '0;
        end else if (we) begin
            mem[ptr_q] <= cls_in;
            ptr_q      <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
            newest_ptr <= ptr_q;
            // newest class enters the low bits, the oldest leaves the top
            window     <= {window[2*WIN-3:0], cls_in};
        end
    end

    assign rd_cls = mem[rd_addr];
    assign wr_ptr = ptr_q;

endmodule

// File: rtl/wtrig_patbank.sv
module wtrig_patbank
    import wtrig_pkg::*;
#(
    parameter int NPAT = 72,
    parameter int WIN  = 8,
    parameter int AW   = 7,
    localparam int DW  = 2 * WIN + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [AW-1:0]   cfg_addr,
    input  logic [DW-1:0]   cfg_data,
    input  logic [2*WIN-1:0] window,
    output logic [NPAT-1:0] hit
);

    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        logic            en_q;
        logic [2*WIN-1:0] pat_q;
        logic            m;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q  <= 1'b0;
                pat_q <= '0;
            end else if (cfg_we && cfg_addr == AW'(g)) begin
                en_q  <= cfg_data[DW-1];
                pat_q <= cfg_data[2*WIN-1:0];
            end
        end

        always_comb begin
            m = en_q;
            for (int j = 0; j < WIN; j++) begin
                if (!pos_match(cls_e'(window[2*j +: 2]), pat_q[2*j +: 2])) m = 1'b0;
            end
        end

        assign hit[g] = m;
    end

endmodule

// File: rtl/wtrig_prio.sv
module wtrig_prio #(
    parameter int NPAT = 72,
    localparam int IW  = $clog2(NPAT)
) (
    input  logic [NPAT-1:0] hit,
    output logic            any,
    output logic [IW-1:0]   id
);

    always_comb begin
        any = 1'b0;
        id  = '0;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any = 1'b1;
                id  = IW'(i);
            end
        end
    end

endmodule

// File: rtl/wtrig_top.sv
module wtrig_top
    import wtrig_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int WIN   = 8,
    parameter int NPAT  = 72,
    localparam int PW   = $clog2(DEPTH),
    localparam int IW   = $clog2(NPAT),
    localparam int DW   = 2 * WIN + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic          cmp_hi,
    input  logic          cmp_lo,
    input  logic          cfg_we,
    input  logic [IW-1:0] cfg_addr,
    input  logic [DW-1:0] cfg_data,
    input  logic          arm,
    input  logic [PW-1:0] rd_addr,
    output logic [1:0]    rd_class,
    output logic          armed,
    output logic          trig,
    output logic [PW-1:0] trig_ptr,
    output logic [IW-1:0] trig_id
);

    logic             accept;
    cls_e             cls_now;
    cls_e             rd_cls;
    logic [PW-1:0]    wp;
    logic [PW-1:0]    newest_ptr;
    logic [2*WIN-1:0] window;
    logic             w_new;
    logic [NPAT-1:0]  hit_vec;
    logic             hit_any;
    logic [IW-1:0]    hit_id;

    // evaluation stage
    logic             s1_v;
    logic             s1_hit;
    logic [IW-1:0]    s1_id;
    logic [PW-1:0]    s1_ptr;

    assign cls_now = classify(cmp_hi, cmp_lo);
    // a pending hit in the evaluation stage already closes acquisition
    assign accept  = smp_valid && armed && !trig && !(s1_v && s1_hit) && !arm;

    wtrig_history #(.DEPTH(DEPTH), .WIN(WIN)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .we         (accept),
        .cls_in     (cls_now),
        .rd_addr    (rd_addr),
        .rd_cls     (rd_cls),
        .wr_ptr     (wp),
        .newest_ptr (newest_ptr),
        .window     (window)
    );

    wtrig_patbank #(.NPAT(NPAT), .WIN(WIN), .AW(IW)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .window   (window),
        .hit      (hit_vec)
    );

    wtrig_prio #(.NPAT(NPAT)) u_prio (
        .hit (hit_vec),
        .any (hit_any),
        .id  (hit_id)
    );

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            w_new <= 1'b0;
            s1_v  <= 1'b0;
        end else begin
            w_new <= accept;
            s1_v  <= w_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_hit <= 1'b0;
            s1_id  <= '0;
            s1_ptr <= '0;
        end else begin
            s1_hit <= hit_any;
            s1_id  <= hit_id;
            s1_ptr <= newest_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            trig     <= 1'b0;
            trig_ptr <= '0;
            trig_id  <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            trig  <= 1'b0;
        end else if (s1_v && s1_hit && !trig) begin
            trig     <= 1'b1;
            trig_ptr <= s1_ptr;
            trig_id  <= s1_id;
        end
    end

    assign rd_class = rd_cls;

endmodule

// File: rtl/wtrig_chk.sv
module wtrig_chk #(
    parameter int NPAT = 72,
    parameter int PW   = 7,
    parameter int IW   = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          arm,
    input logic          armed,
    input logic          trig,
    input logic          s1_v,
    input logic          s1_hit,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] trig_ptr,
    input logic [IW-1:0] trig_id
);

    p_trig_needs_arm_r6: assert property (@(posedge clk) disable iff (rst)
        trig |-> armed);

    p_idle_no_write_r6: assert property (@(posedge clk) disable iff (rst)
        !armed |=> $stable(wr_ptr));

    p_rise_from_hit_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(trig) |-> $past(s1_v && s1_hit));

    p_result_held_r8: assert property (@(posedge clk) disable iff (rst)
        (trig && !arm) |=> (trig && $stable(trig_ptr) && $stable(trig_id)));

    p_id_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        trig |-> (int'(trig_id) < NPAT));

    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        trig |=> $stable(wr_ptr));

    p_arm_effect_r10: assert property (@(posedge clk) disable iff (rst)
        arm |=> (armed && !trig));

endmodule

bind wtrig_top wtrig_chk #(.NPAT(NPAT), .PW(PW), .IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .arm      (arm),
    .armed    (armed),
    .trig     (trig),
    .s1_v     (s1_v),
    .s1_hit   (s1_hit),
    .wr_ptr   (wp),
    .trig_ptr (trig_ptr),
    .trig_id  (trig_id)
);

// File: tb/wtrig_top_test.sv
module wtrig_top_test;

    localparam int DEPTH = 128;
    localparam int NP    = 72;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic        cmp_hi = 1'b0;
    logic        cmp_lo = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [16:0] cfg_data = '0;
    logic        arm = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [1:0]  rd_class;
    logic        armed;
    logic        trig;
    logic [6:0]  trig_ptr;
    logic [6:0]  trig_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    wtrig_top uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .arm(arm),
        .rd_addr(rd_addr), .rd_class(rd_class), .armed(armed), .trig(trig),
        .trig_ptr(trig_ptr), .trig_id(trig_id)
    );

    // ---------------- behavioural reference ----------------
    int          m_hist [DEPTH];
    int          m_ptr, m_tptr, m_tid, m_pptr, m_s1id, m_s1ptr;
    bit          m_armed, m_trig, m_pv, m_s1v, m_s1hit;
    bit [16:0]   m_cfg [NP];

    function automatic int cls_of(bit hi, bit lo);
        if (hi && lo)  return 2;
        if (!hi && lo) return 3;
        if (!hi && !lo) return 1;
        return 0;
    endfunction

    function automatic bit code_ok(int c, int code);
        return (code == 0) || (c != 0 && c == code);
    endfunction

    task automatic find_match(input int nptr, output bit h, output int id);
        h = 0; id = 0;
        for (int p = 0; p < NP; p++) begin
            bit ok;
            ok = m_cfg[p][16];
            for (int j = 0; j < 8; j++) begin
                if (!code_ok(m_hist[(nptr - j + DEPTH) % DEPTH], int'(m_cfg[p][2*j +: 2]))) ok = 0;
            end
            if (ok && !h) begin h = 1; id = p; end
        end
    endtask

    always @(posedge clk) begin
        bit acc, nh;
        int nid;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_hist[i] = 0;
            for (int p = 0; p < NP; p++) m_cfg[p] = '0;
            m_ptr = 0; m_tptr = 0; m_tid = 0; m_pptr = 0; m_s1id = 0; m_s1ptr = 0;
            m_armed = 0; m_trig = 0; m_pv = 0; m_s1v = 0; m_s1hit = 0;
        end else begin
            acc = smp_valid && m_armed && !m_trig && !(m_s1v && m_s1hit) && !arm;
            nh = 0; nid = 0;
            if (m_pv) find_match(m_pptr, nh, nid);
            if (arm) begin
                m_armed = 1; m_trig = 0;
            end else if (m_s1v && m_s1hit && !m_trig) begin
                m_trig = 1; m_tptr = m_s1ptr; m_tid = m_s1id;
            end
            m_s1v = arm ? 0 : m_pv;
            m_s1hit = nh; m_s1id = nid; m_s1ptr = m_pptr;
            m_pv = arm ? 0 : acc;
            if (acc) begin
                m_pptr = m_ptr;
                m_hist[m_ptr] = cls_of(cmp_hi, cmp_lo);
                m_ptr = (m_ptr + 1) % DEPTH;
            end
            if (cfg_we && cfg_addr < NP) m_cfg[cfg_addr] = cfg_data;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        if (rst) return;
        chk(trig == m_trig, "R7 trig", int'(trig), int'(m_trig));
        chk(armed == m_armed, "R6 armed", int'(armed), int'(m_armed));
        if (m_trig) begin
            chk(int'(trig_ptr) == m_tptr, "R8 trig_ptr", int'(trig_ptr), m_tptr);
            chk(int'(trig_id) == m_tid, "R8 trig_id", int'(trig_id), m_tid);
        end
        chk(int'(rd_class) == m_hist[rd_addr], "R5 R12 rd_class", int'(rd_class), m_hist[rd_addr]);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    // c: 1 Low, 2 High, 3 Middle, 0 invalid
    task automatic drive_cls(input int c);
        case (c)
            2: begin cmp_hi = 1; cmp_lo = 1; end
            3: begin cmp_hi = 0; cmp_lo = 1; end
            1: begin cmp_hi = 0; cmp_lo = 0; end
            default: begin cmp_hi = 1; cmp_lo = 0; end
        endcase
    endtask

    task automatic send(input int c);
        drive_cls(c);
        smp_valid = 1;
        step();
        smp_valid = 0;
    endtask

    task automatic wcfg(input int addr, input bit [16:0] d);
        cfg_we = 1; cfg_addr = 7'(addr); cfg_data = d;
        step();
        cfg_we = 0;
    endtask

    task automatic do_arm();
        arm = 1;
        step();
        arm = 0;
    endtask

    task automatic peek(input int addr, input int exp, input string req);
        rd_addr = 7'(addr);
        step();
        chk(int'(rd_class) == exp, req, int'(rd_class), exp);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        bit [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) step();
        rst = 0;
        step();
        chk(trig == 0, "R6 reset trig", int'(trig), 0);
        chk(armed == 0, "R6 reset armed", int'(armed), 0);
        chk(rd_class == 2'b00, "R12 reset history", int'(rd_class), 0);

        // R6: samples while disarmed are not stored
        send(2); send(2);
        peek(0, 0, "R6 disarmed sample ignored");

        // R11 R2 R4: alternating pattern on id 5, catch-all at ignored address 100
        wcfg(5, 17'h16666);
        wcfg(100, 17'h10000);
        do_arm();
        for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 2 : 1);
        repeat (3) step();
        chk(trig == 1, "R11 alternating fires", int'(trig), 1);
        chk(trig_ptr == 7'd8, "R8 R11 newest entry", int'(trig_ptr), 8);
        chk(trig_id == 7'd5, "R8 R11 pattern id", int'(trig_id), 5);
        // R9: sample 9 written, sample 10 not
        peek(9, 1, "R9 one extra sample stored");
        peek(10, 0, "R9 history frozen");
        peek(0, 2, "R1 High code");
        peek(1, 1, "R1 Low code");

        // R10: arm with a coincident sample; that sample is dropped
        wcfg(5, 17'h00000);
        wcfg(4, 17'h1FFFF);
        drive_cls(3); smp_valid = 1; arm = 1;
        step();
        arm = 0; smp_valid = 0;
        chk(trig == 0, "R10 arm clears trig", int'(trig), 0);
        peek(10, 0, "R10 coincident sample dropped");
        send(3);
        peek(10, 3, "R10 resume at next entry, R1 Middle code");

        // R3: invalid samples never satisfy Middle
        for (int i = 0; i < 10; i++) send(0);
        repeat (3) step();
        chk(trig == 0, "R3 invalid only matches any", int'(trig), 0);
        peek(12, 0, "R1 invalid code");

        // R2 R8: two patterns match the same window, lowest id wins
        wcfg(4, 17'h00000);
        wcfg(2, 17'h1000B);
        wcfg(3, 17'h10003);
        send(2); send(3);
        repeat (3) step();
        chk(trig == 1, "R2 position order fires", int'(trig), 1);
        chk(trig_id == 7'd2, "R8 lowest id wins", int'(trig_id), 2);
        wcfg(2, 17'h00000);
        wcfg(3, 17'h00000);

        // R5 R4 R7: random stream across many wraps, model compares every cycle
        wcfg(7, 17'h1FF00);
        wcfg(20, 17'h10055);
        wcfg(71, 17'h1AAAA);
        do_arm();
        for (int t = 0; t < 6000; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_addr = lfsr[6:0];
            smp_valid = lfsr[8] | lfsr[9];
            drive_cls(int'(lfsr[11:10]));
            arm = trig && (lfsr[3:0] == 4'h0);
            if (t == 3000) begin
                cfg_we = 1; cfg_addr = 7'd7; cfg_data = 17'h00000;
            end else begin
                cfg_we = 0;
            end
            step();
        end
        smp_valid = 0; arm = 0; cfg_we = 0;
        step();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule